// File: doc/BRIEF.md
# Carry-Reload Integer Clock Divider

This block turns a fast reference clock into a slow sample-rate timebase by dividing it by a fixed integer, 2229 by default. With a 98.304 MHz reference this yields a rate close to 44.1 kHz, about 52 ppm off, which is accepted as is. The block does not compare the count against the terminal value. Instead it uses a presettable up-counter, and one extra flip-flop catches the counter's carry-out. That flip-flop then forces a synchronous reload of a preset value.

Two outputs are derived from the same count. `ce_pulse` is high for exactly one reference clock per output period, for use as a clock enable inside the chip. `conv_clk` is the most significant bit of the counter. It toggles at the same rate with a long high time and is meant to clock an external converter. Every stage is clocked by the one reference clock. A synchronous reset restarts the sequence from the preset value.

The carry flip-flop is the state of a two-state machine. In state PH_RUN the counter increments every clock. The transition PH_RUN to PH_CARRY is taken when the increment carries out of the counter's top bit. In PH_CARRY the pulse is raised and the counter reloads its preset. The transition PH_CARRY to PH_RUN is unconditional after one clock. Reset forces PH_RUN. With a 12-bit counter the preset is 4096 - 2228 = 1868. The sequence therefore visits counts 1868 through 4095 and then the single carry state, which is 2229 clocks in all.

Top module: `clkdiv_carry_reload`

## Requirements
- R1: Successive rising edges of `ce_pulse` are exactly DIV_RATIO (2229) clocks apart, forever.
- R2: `ce_pulse` is high for exactly one clock per period, and it is never high on two consecutive clocks.
- R3: In every period `conv_clk` (counter bit 11) is high for exactly 2048 consecutive clocks, which are the counts 2048 through 4095.
- R4: `conv_clk` is low during the `ce_pulse` clock and the 180 clocks that follow it. This gives 181 low clocks per period, and `ce_pulse` and `conv_clk` are never high together.
- R5: While `rst` is sampled high, both outputs read 0 after the edge. Counting from the first edge with `rst` low as edge 1, `conv_clk` first rises after edge 180 and `ce_pulse` first rises after edge 2228.
- R6: Asserting `rst` for one clock in the middle of a period discards the partial count. The sequence restarts with the same timing as in R5.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; all state changes on its rising edge |
| rst | input | 1 | Synchronous active-high reset |
| ce_pulse | output | 1 | One-clock enable pulse, once every DIV_RATIO clocks |
| conv_clk | output | 1 | Long-duty output at the divided rate (counter MSB) |

## Verification
The bench samples the outputs at several points in each period: at the preset, at the bit-11 rise at count 2048, at the top count 4095, at the carry state, and at the clock after the reload, across three periods. If the preset is off by one, the pulse drifts a clock per period, and the later table entries expose that. A full-period scan counts pulse clocks and high and low `conv_clk` clocks. This catches a carry state that lasts two clocks, a reload that leaves a stale nonzero count so `conv_clk` is high during the pulse, and a counter that skips the carry state. A reset in the middle of a period must give exactly the post-reset timing. A reset that cleared only the carry bit, or only the count, would place the next pulse at the wrong clock.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;

    // Phase of the divider: the encoding doubles as the overflow bit.
    typedef enum logic {
        PH_RUN   = 1'b0,
        PH_CARRY = 1'b1
    } phase_e;

    // Preset so that (2**width - preset) counting states plus one carry
    // state add up to the requested ratio.
    function automatic int preset_for(input int ratio, input int width);
        return (1 << width) - (ratio - 1);
    endfunction

endpackage

// File: rtl/clkdiv_count.sv
module clkdiv_count #(
    parameter int CNT_W      = 12,
    parameter int PRESET_VAL = 1868
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load,
    output logic [CNT_W-1:0] cnt_q,
    output logic             carry
);

    localparam logic [CNT_W-1:0] PRESET = CNT_W'(PRESET_VAL);

    logic [CNT_W-1:0] sum;

    // Increment with its natural carry-out; no terminal-count compare.
    always_comb begin
        {carry, sum} = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
    end

    always_ff @(posedge clk) begin
        if (rst || load) begin
            cnt_q <= PRESET;
        end else begin
            cnt_q <= sum;
        end
    end

    // A reload request from the phase machine lands the preset next clock.
    assert_reload_preset_R4: assert property (@(posedge clk) disable iff (rst)
        load |=> (cnt_q == PRESET));

    // The carry only ever appears when the count sits at its top value.
    assert_carry_at_top_R3: assert property (@(posedge clk) disable iff (rst)
        carry |=> (cnt_q == '0));

endmodule

// File: rtl/clkdiv_phase.sv
module clkdiv_phase
    import clkdiv_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic carry_in,
    output logic load_o,
    output logic pulse_o
);

    phase_e state_q;
    phase_e state_d;

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PH_RUN:   state_d = carry_in ? PH_CARRY : PH_RUN;
            PH_CARRY: state_d = PH_RUN;
            default:  state_d = PH_RUN;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= PH_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs, decoded straight from the registered state
    always_comb begin
        load_o  = 1'b0;
        pulse_o = 1'b0;
        unique case (state_q)
            PH_RUN: begin
                load_o  = 1'b0;
                pulse_o = 1'b0;
            end
            PH_CARRY: begin
                load_o  = 1'b1;
                pulse_o = 1'b1;
            end
            default: begin
                load_o  = 1'b0;
                pulse_o = 1'b0;
            end
        endcase
    end

    // The carry state lasts exactly one clock.
    assert_carry_single_R2: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_CARRY) |=> (state_q == PH_RUN));

    // Entering the carry state requires a carry from the counter.
    assert_carry_entry_R1: assert property (@(posedge clk) disable iff (rst)
        (state_q == PH_RUN && !carry_in) |=> (state_q == PH_RUN));

endmodule

// File: rtl/clkdiv_carry_reload.sv
module clkdiv_carry_reload #(
    parameter int DIV_RATIO = 2229,
    parameter int CNT_W     = 12
) (
    input  logic clk,
    input  logic rst,
    output logic ce_pulse,
    output logic conv_clk
);

    localparam int PRESET_VAL = clkdiv_pkg::preset_for(DIV_RATIO, CNT_W);
    localparam int GAP_W      = $clog2(DIV_RATIO) + 2;

    logic [CNT_W-1:0] cnt_q;
    logic             carry;
    logic             load;
    logic             pulse;

    clkdiv_count #(
        .CNT_W      (CNT_W),
        .PRESET_VAL (PRESET_VAL)
    ) u_count (
        .clk   (clk),
        .rst   (rst),
        .load  (load),
        .cnt_q (cnt_q),
        .carry (carry)
    );

    clkdiv_phase u_phase (
        .clk      (clk),
        .rst      (rst),
        .carry_in (carry),
        .load_o   (load),
        .pulse_o  (pulse)
    );

    assign ce_pulse = pulse;
    assign conv_clk = cnt_q[CNT_W-1];

    // Period checker: clocks since the last pulse, compared at each pulse.
    logic [GAP_W-1:0] gap_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            gap_q  <= '0;
            seen_q <= 1'b0;
        end else if (ce_pulse) begin
            gap_q  <= GAP_W'(1);
            seen_q <= 1'b1;
        end else begin
            gap_q  <= gap_q + GAP_W'(1);
        end
    end

    assert_period_R1: assert property (@(posedge clk) disable iff (rst)
        (ce_pulse && seen_q) |-> (gap_q == GAP_W'(DIV_RATIO)));

    assert_pulse_one_clock_R2: assert property (@(posedge clk) disable iff (rst)
        ce_pulse |=> !ce_pulse);

    assert_no_overlap_R4: assert property (@(posedge clk) disable iff (rst)
        ce_pulse |-> (!conv_clk && cnt_q == '0));

    assert_reset_state_R5: assert property (@(posedge clk)
        rst |=> (!ce_pulse && !conv_clk));

endmodule

// File: tb/tb_clkdiv_carry_reload.sv
module tb_clkdiv_carry_reload;

    localparam int RATIO = 2229;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_pulse;
    logic conv_clk;

    int n_cmp  = 0;
    int n_bad  = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    clkdiv_carry_reload dut (
        .clk      (clk),
        .rst      (rst),
        .ce_pulse (ce_pulse),
        .conv_clk (conv_clk)
    );

    // {clocks since reset release [15:0], expected ce_pulse, expected conv_clk}
    localparam int NVEC = 14;
    localparam logic [17:0] VEC [NVEC] = '{
        {16'd0,    1'b0, 1'b0},
        {16'd1,    1'b0, 1'b0},
        {16'd179,  1'b0, 1'b0},
        {16'd180,  1'b0, 1'b1},
        {16'd2227, 1'b0, 1'b1},
        {16'd2228, 1'b1, 1'b0},
        {16'd2229, 1'b0, 1'b0},
        {16'd2408, 1'b0, 1'b0},
        {16'd2409, 1'b0, 1'b1},
        {16'd4456, 1'b0, 1'b1},
        {16'd4457, 1'b1, 1'b0},
        {16'd4458, 1'b0, 1'b0},
        {16'd6685, 1'b0, 1'b1},
        {16'd6686, 1'b1, 1'b0}
    };

    task automatic check(input string req, input string what,
                         input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d (cycle %0d)",
                     req, what, act, exp, cyc);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        cyc++;
    endtask

    initial begin
        // R5: outputs while reset is applied
        repeat (3) @(negedge clk);
        check("R5", "ce_pulse in reset", int'(ce_pulse), 0);
        check("R5", "conv_clk in reset", int'(conv_clk), 0);
        rst = 1'b0;
        cyc = 0;

        // Vector walk: R5 first-period timing, R3/R4 edges, R1 later periods
        for (int i = 0; i < NVEC; i++) begin
            int target;
            target = int'(VEC[i][17:2]);
            while (cyc < target) tick();
            check((target < 2229) ? "R5" : "R1", "ce_pulse",
                  int'(ce_pulse), int'(VEC[i][1]));
            check((target < 2229) ? "R5/R3" : "R3/R4", "conv_clk",
                  int'(conv_clk), int'(VEC[i][0]));
        end

        // Full-period scan after the pulse at clock 6686
        begin
            int ce_cnt;
            int hi_cnt;
            int overlap;
            int last_ce;
            int first_hi;
            int lo_run;
            ce_cnt = 0; hi_cnt = 0; overlap = 0; last_ce = -1;
            first_hi = -1; lo_run = 0;
            for (int k = 1; k <= RATIO; k++) begin
                tick();
                if (ce_pulse) begin ce_cnt++; last_ce = k; end
                if (conv_clk) begin
                    hi_cnt++;
                    if (first_hi < 0) first_hi = k;
                end else if (first_hi < 0) begin
                    lo_run++;
                end
                if (ce_pulse && conv_clk) overlap++;
            end
            check("R2", "pulses per period", ce_cnt, 1);
            check("R1", "pulse position in period", last_ce, RATIO);
            check("R3", "conv_clk high clocks", hi_cnt, 2048);
            check("R4", "low clocks after pulse", lo_run, 180);
            check("R4", "pulse/conv overlap", overlap, 0);
        end

        // R6: reset in the middle of a period
        repeat (1000) tick();
        rst = 1'b1;
        tick();
        check("R6", "ce_pulse after mid reset", int'(ce_pulse), 0);
        check("R6", "conv_clk after mid reset", int'(conv_clk), 0);
        rst = 1'b0;
        cyc = 0;
        while (cyc < 179) tick();
        check("R6", "conv_clk before rise", int'(conv_clk), 0);
        tick();
        check("R6", "conv_clk rise", int'(conv_clk), 1);
        while (cyc < 2227) tick();
        check("R6", "ce_pulse one early", int'(ce_pulse), 0);
        tick();
        check("R6", "ce_pulse restart", int'(ce_pulse), 1);
        tick();
        check("R2", "ce_pulse falls", int'(ce_pulse), 0);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule